// File: doc/BRIEF.md
# GPIO Bank with Sleep-Forced Alternate-Function Override

This block is a bank of general-purpose pins behind a small register bus. Each pin holds an output-data bit, a direction bit, a pull-disable bit, a two-bit alternate-function select and a sleep-keep bit. For every pad the block drives the output level, the output enable and the pull controls. These come either from the pin's own registers or from one of three peripheral sources, called A, B and C.

Software changes data and direction through dedicated set and clear addresses, so one write touches only the pins whose bits are 1. The pull direction follows the output-data bit, and the pull is active only while the pad is not driving. A sleep input `ioforce` returns every pin whose sleep-keep bit is 0 to GPIO control. Pins whose sleep-keep bit is 1 stay with their selected source. When `ioforce` falls, every pin goes back to its programmed selection. Pad inputs are synchronized by two flops before they can be read.

Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle. A write commits on the rising clock edge at which `bus_wr` is high.

Top module: `pinbank_ctrl`

## Requirements
- R1: After a synchronous reset every readable register reads 0. Every pad therefore has output enable 0, pull enabled, pull direction down and output 0.
- R2: A write to address 0x2 ORs the write data into the output-data register. A write to address 0x3 clears the output-data bits where the write data is 1. Data bits that are 0 leave their pins unchanged. A write to address 0x1 loads the register directly, and reads of 0x1, 0x2 and 0x3 return it.
- R3: A write to address 0x5 sets the direction bits where the write data is 1 (1 = output). A write to address 0x6 clears them. A write to address 0x4 loads the register directly, and reads of 0x4, 0x5 and 0x6 return it.
- R4: The pull-disable register (0x7), select-A register (0x8), select-B register (0x9) and sleep-keep register (0xA) each store a written value and return it on read.
- R5: A pin whose effective selection is GPIO (select-A bit 0, select-B bit 0) drives its output-data bit as `pad_out` and its direction bit as `pad_oe`.
- R6: The two select bits choose a source as follows. A=1,B=0 takes `per_a_out` and `per_a_oe`. A=0,B=1 takes the B pair. A=1,B=1 takes the C pair.
- R7: `pad_pull_en` is 1 exactly when the pin's pull-disable bit is 0 and `pad_oe` is 0. `pad_pull_up` equals the pin's output-data bit in every mode.
- R8: While `ioforce` is 1, every pin whose sleep-keep bit is 0 behaves as GPIO regardless of its select bits.
- R9: While `ioforce` is 1, every pin whose sleep-keep bit is 1 keeps the source its select bits choose.
- R10: When `ioforce` is 0, every pin follows its select bits. Pad outputs change in the same cycle as `ioforce`, without a clock edge.
- R11: Address 0x0 returns the pad inputs through a two-flop synchronizer. A level applied before rising edge k is readable after edge k+1 and not after edge k.
- R12: Writes to address 0x0 or to addresses 0xB to 0xF change no register. Reads of 0xB to 0xF return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, commits at the rising edge |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | PINS | Write data, one bit per pin |
| bus_rdata | output | PINS | Combinational read data |
| pad_in | input | PINS | Pad input levels (asynchronous) |
| pad_out | output | PINS | Pad output level |
| pad_oe | output | PINS | Pad output enable |
| pad_pull_en | output | PINS | Pull resistor enable |
| pad_pull_up | output | PINS | Pull direction, 1 = up |
| ioforce | input | 1 | Sleep force toward GPIO control |
| per_a_out | input | PINS | Peripheral A output levels |
| per_a_oe | input | PINS | Peripheral A output enables |
| per_b_out | input | PINS | Peripheral B output levels |
| per_b_oe | input | PINS | Peripheral B output enables |
| per_c_out | input | PINS | Peripheral C output levels |
| per_c_oe | input | PINS | Peripheral C output enables |

## Verification
The pad mux is driven with a fixed pattern of all four select codes spread across neighbouring pins, each peripheral source carrying a distinct value. A wrong source mapping therefore shows up as a wrong bit on a specific pin. The same pattern is repeated with `ioforce` high and a mixed sleep-keep mask, which separates forced pins from kept ones, and then with `ioforce` low to confirm the return to the programmed selection. Random sequences mix set, clear and direct writes on sparse and dense masks with random peripheral values and sleep toggles. This catches set/clear mix-ups and pull logic that ignores direction. Directed writes to the unmapped and read-only addresses, together with a timed pad-input step, cover the ignore rule and the exact synchronizer latency.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_PIN_IN   = 4'h0,
        RA_OUT      = 4'h1,
        RA_OUT_SET  = 4'h2,
        RA_OUT_CLR  = 4'h3,
        RA_DIR      = 4'h4,
        RA_DIR_SET  = 4'h5,
        RA_DIR_CLR  = 4'h6,
        RA_PULL_OFF = 4'h7,
        RA_FSEL_A   = 4'h8,
        RA_FSEL_B   = 4'h9,
        RA_KEEP     = 4'hA
    } reg_addr_e;

    localparam logic [ADDR_W-1:0] RA_LAST = RA_KEEP;

    // Source code is {select-B bit, select-A bit}
    typedef enum logic [1:0] {
        SRC_GPIO = 2'b00,
        SRC_A    = 2'b01,
        SRC_B    = 2'b10,
        SRC_C    = 2'b11
    } src_e;

    typedef struct packed {
        logic lvl;
        logic en;
    } drive_t;

    // Sleep force wins over the select bits unless the pin is kept.
    function automatic src_e eff_src(input logic sel_a, input logic sel_b,
                                     input logic force_in, input logic keep);
        if (force_in && !keep)
            return SRC_GPIO;
        return src_e'({sel_b, sel_a});
    endfunction

    function automatic drive_t pick_drive(input src_e s, input drive_t g,
                                          input drive_t pa, input drive_t pb,
                                          input drive_t pc);
        drive_t r;
        case (s)
            SRC_A:   r = pa;
            SRC_B:   r = pb;
            SRC_C:   r = pc;
            default: r = g;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++)
                chain[s] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++)
                chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   rdata,
    output logic [PINS-1:0]   dout,
    output logic [PINS-1:0]   dir,
    output logic [PINS-1:0]   pull_off,
    output logic [PINS-1:0]   sel_a,
    output logic [PINS-1:0]   sel_b,
    output logic [PINS-1:0]   keep
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout     <= '0;
            dir      <= '0;
            pull_off <= '0;
            sel_a    <= '0;
            sel_b    <= '0;
            keep     <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_OUT:      dout     <= wdata;
                RA_OUT_SET:  dout     <= dout | wdata;
                RA_OUT_CLR:  dout     <= dout & ~wdata;
                RA_DIR:      dir      <= wdata;
                RA_DIR_SET:  dir      <= dir | wdata;
                RA_DIR_CLR:  dir      <= dir & ~wdata;
                RA_PULL_OFF: pull_off <= wdata;
                RA_FSEL_A:   sel_a    <= wdata;
                RA_FSEL_B:   sel_b    <= wdata;
                RA_KEEP:     keep     <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            RA_PIN_IN:                      rdata = pin_in;
            RA_OUT, RA_OUT_SET, RA_OUT_CLR: rdata = dout;
            RA_DIR, RA_DIR_SET, RA_DIR_CLR: rdata = dir;
            RA_PULL_OFF:                    rdata = pull_off;
            RA_FSEL_A:                      rdata = sel_a;
            RA_FSEL_B:                      rdata = sel_b;
            RA_KEEP:                        rdata = keep;
            default:                        rdata = '0;
        endcase
    end
endmodule

// File: rtl/pinbank_mux.sv
module pinbank_mux
    import pinbank_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            ioforce,
    input  logic [PINS-1:0] dout,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] pull_off,
    input  logic [PINS-1:0] sel_a,
    input  logic [PINS-1:0] sel_b,
    input  logic [PINS-1:0] keep,
    input  logic [PINS-1:0] per_a_out,
    input  logic [PINS-1:0] per_a_oe,
    input  logic [PINS-1:0] per_b_out,
    input  logic [PINS-1:0] per_b_oe,
    input  logic [PINS-1:0] per_c_out,
    input  logic [PINS-1:0] per_c_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_pull_en,
    output logic [PINS-1:0] pad_pull_up
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        src_e   src;
        drive_t d_gpio, d_a, d_b, d_c, d_sel;

        assign d_gpio = '{lvl: dout[i],      en: dir[i]};
        assign d_a    = '{lvl: per_a_out[i], en: per_a_oe[i]};
        assign d_b    = '{lvl: per_b_out[i], en: per_b_oe[i]};
        assign d_c    = '{lvl: per_c_out[i], en: per_c_oe[i]};

        always_comb begin
            src   = eff_src(sel_a[i], sel_b[i], ioforce, keep[i]);
            d_sel = pick_drive(src, d_gpio, d_a, d_b, d_c);
        end

        assign pad_out[i]     = d_sel.lvl;
        assign pad_oe[i]      = d_sel.en;
        assign pad_pull_en[i] = !pull_off[i] && !d_sel.en;
        assign pad_pull_up[i] = dout[i];
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int PINS = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_pull_en,
    output logic [PINS-1:0]   pad_pull_up,
    input  logic              ioforce,
    input  logic [PINS-1:0]   per_a_out,
    input  logic [PINS-1:0]   per_a_oe,
    input  logic [PINS-1:0]   per_b_out,
    input  logic [PINS-1:0]   per_b_oe,
    input  logic [PINS-1:0]   per_c_out,
    input  logic [PINS-1:0]   per_c_oe
);
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] dout_q, dir_q, pull_off_q, sel_a_q, sel_b_q, keep_q;

    pinbank_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pad_in),
        .q_sync  (pin_sync)
    );

    pinbank_regs #(.PINS(PINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_in   (pin_sync),
        .rdata    (bus_rdata),
        .dout     (dout_q),
        .dir      (dir_q),
        .pull_off (pull_off_q),
        .sel_a    (sel_a_q),
        .sel_b    (sel_b_q),
        .keep     (keep_q)
    );

    pinbank_mux #(.PINS(PINS)) u_mux (
        .ioforce     (ioforce),
        .dout        (dout_q),
        .dir         (dir_q),
        .pull_off    (pull_off_q),
        .sel_a       (sel_a_q),
        .sel_b       (sel_b_q),
        .keep        (keep_q),
        .per_a_out   (per_a_out),
        .per_a_oe    (per_a_oe),
        .per_b_out   (per_b_out),
        .per_b_oe    (per_b_oe),
        .per_c_out   (per_c_out),
        .per_c_oe    (per_c_oe),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up)
    );
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
#(
    parameter int PINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_in,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_pull_en,
    input logic [PINS-1:0]   pad_pull_up,
    input logic              ioforce,
    input logic [PINS-1:0]   dout,
    input logic [PINS-1:0]   dir,
    input logic [PINS-1:0]   pull_off,
    input logic [PINS-1:0]   keep
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 2'd2)
            age <= age + 2'd1;
    end

    a_r2_set_ors: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_OUT_SET) |=> (dout == ($past(dout) | $past(bus_wdata))));

    a_r3_clr_masks: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_DIR_CLR) |=> (dir == ($past(dir) & ~$past(bus_wdata))));

    a_r7_pull_gate: assert property (@(posedge clk) disable iff (rst)
        ((pad_pull_en & (pull_off | pad_oe)) == '0) && (pad_pull_up == dout));

    a_r8_force_gpio: assert property (@(posedge clk) disable iff (rst)
        ioforce |-> ((((pad_out ^ dout) | (pad_oe ^ dir)) & ~keep) == '0));

    a_r11_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && bus_addr == RA_PIN_IN) |-> (bus_rdata == $past(pad_in, 2)));

    a_r12_no_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr > RA_LAST || bus_addr == RA_PIN_IN))
        |=> $stable({dout, dir, pull_off, keep}));
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.PINS(PINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up),
    .ioforce     (ioforce),
    .dout        (dout_q),
    .dir         (dir_q),
    .pull_off    (pull_off_q),
    .keep        (keep_q)
);

// File: tb/pinbank_ctrl_test.sv
`timescale 1ns/1ps
module pinbank_ctrl_test;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic         ioforce = 1'b0;
    logic [N-1:0] pa_o = '0, pa_e = '0, pb_o = '0, pb_e = '0, pc_o = '0, pc_e = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the registers
    logic [N-1:0] m_out = '0, m_dir = '0, m_poff = '0, m_sa = '0, m_sb = '0, m_keep = '0;

    always #2 clk = ~clk;

    pinbank_ctrl #(.PINS(N)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .ioforce(ioforce),
        .per_a_out(pa_o), .per_a_oe(pa_e), .per_b_out(pb_o), .per_b_oe(pb_e),
        .per_c_out(pc_o), .per_c_oe(pc_e)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_reg(input logic [3:0] a);
        case (a)
            4'h1, 4'h2, 4'h3: return m_out;
            4'h4, 4'h5, 4'h6: return m_dir;
            4'h7: return m_poff;
            4'h8: return m_sa;
            4'h9: return m_sb;
            4'hA: return m_keep;
            default: return '0;
        endcase
    endfunction

    // which = 0: out, 1: oe
    function automatic logic [N-1:0] exp_drive(input int which);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            logic [1:0] s;
            s = (ioforce && !m_keep[i]) ? 2'b00 : {m_sb[i], m_sa[i]};
            case (s)
                2'b01:   r[i] = which == 0 ? pa_o[i] : pa_e[i];
                2'b10:   r[i] = which == 0 ? pb_o[i] : pb_e[i];
                2'b11:   r[i] = which == 0 ? pc_o[i] : pc_e[i];
                default: r[i] = which == 0 ? m_out[i] : m_dir[i];
            endcase
        end
        return r;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            4'h1: m_out = d;
            4'h2: m_out = m_out | d;
            4'h3: m_out = m_out & ~d;
            4'h4: m_dir = d;
            4'h5: m_dir = m_dir | d;
            4'h6: m_dir = m_dir & ~d;
            4'h7: m_poff = d;
            4'h8: m_sa = d;
            4'h9: m_sb = d;
            4'hA: m_keep = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic check_pads(input string rdrv, input string rpull);
        logic [N-1:0] oe_x;
        #0.5;
        oe_x = exp_drive(1);
        check(rdrv, pad_out, exp_drive(0));
        check(rdrv, pad_oe, oe_x);
        check(rpull, pad_pull_en, ~m_poff & ~oe_x);
        check(rpull, pad_pull_up, m_out);
    endtask

    initial begin
        logic [N-1:0] v;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            check("R1", v, '0);
        end
        check("R1", pad_oe, '0);
        check("R1", pad_pull_en, '1);
        check("R1", pad_pull_up, '0);
        check("R1", pad_out, '0);

        // R2: data set/clear
        wr(4'h1, 32'h0000_000F);
        wr(4'h2, 32'h0000_00F0);
        rd(4'h1, v); check("R2", v, 32'h0000_00FF);
        wr(4'h3, 32'h0000_003C);
        rd(4'h2, v); check("R2", v, 32'h0000_00C3);
        wr(4'h2, 32'h0);
        rd(4'h3, v); check("R2", v, 32'h0000_00C3);

        // R3: direction set/clear
        wr(4'h5, 32'hF000_0001);
        wr(4'h6, 32'h3000_0000);
        rd(4'h4, v); check("R3", v, 32'hC000_0001);
        wr(4'h4, 32'h0000_00FF);
        rd(4'h6, v); check("R3", v, 32'h0000_00FF);

        // R5: GPIO mode pads
        @(negedge clk);
        check_pads("R5", "R7");
        check("R5", pad_out, 32'h0000_00C3);

        // R4 / R6: select codes on pins 0..3, distinct source values
        wr(4'h7, 32'h0000_0F00);
        rd(4'h7, v); check("R4", v, 32'h0000_0F00);
        wr(4'h8, 32'h0000_000A);   // pin1 A, pin3 C
        wr(4'h9, 32'h0000_000C);   // pin2 B, pin3 C
        rd(4'h8, v); check("R4", v, 32'h0000_000A);
        rd(4'h9, v); check("R4", v, 32'h0000_000C);
        pa_o = 32'h0000_0002; pa_e = 32'h0000_0002;
        pb_o = 32'h0000_0000; pb_e = 32'h0000_0000;
        pc_o = 32'h0000_0008; pc_e = 32'h0000_0008;
        wr(4'h1, 32'h0000_0005);
        check_pads("R6", "R7");
        check("R6", pad_out & 32'hF, 32'h0000_000B);   // pin0 gpio=1, pin1 A=1, pin2 B=0, pin3 C=1
        check("R6", pad_oe & 32'hF, 32'h0000_000B);    // pin0 dir=1, pin2 B oe=0
        check("R7", pad_pull_en & 32'hF, 32'h0000_0004);

        // R8 / R9: sleep force, keep pin3 only
        wr(4'hA, 32'h0000_0008);
        rd(4'hA, v); check("R4", v, 32'h0000_0008);
        @(negedge clk);
        ioforce = 1'b1;
        check_pads("R8", "R7");
        check("R8", pad_out & 32'h7, 32'h0000_0005);   // pins 0..2 now gpio data 1,0,1
        check("R9", pad_oe & 32'h8, 32'h0000_0008);    // pin3 stays C
        ioforce = 1'b0;
        check_pads("R10", "R7");
        check("R10", pad_out & 32'hF, 32'h0000_000B);

        // R11: synchronizer latency
        @(negedge clk);
        pad_in = 32'hA5A5_5A5A;
        rd(4'h0, v); check("R11", v, '0);
        @(negedge clk);
        rd(4'h0, v); check("R11", v, '0);
        @(negedge clk);
        rd(4'h0, v); check("R11", v, 32'hA5A5_5A5A);

        // R12: unmapped and read-only writes ignored
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'hB, 32'hFFFF_FFFF);
        wr(4'hF, 32'hFFFF_FFFF);
        for (int a = 1; a < 16; a++) begin
            rd(4'(a), v);
            check("R12", v, exp_reg(4'(a)));
        end
        rd(4'h0, v); check("R12", v, 32'hA5A5_5A5A);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [3:0]   a;
            logic [N-1:0] d;
            a = 4'($urandom_range(0, 15));
            d = ($urandom() % 2) ? $urandom() : ($urandom() & $urandom() & $urandom());
            pa_o = $urandom(); pa_e = $urandom();
            pb_o = $urandom(); pb_e = $urandom();
            pc_o = $urandom(); pc_e = $urandom();
            wr(a, d);
            ioforce = 1'($urandom() % 2);
            check_pads("R6", "R7");
            a = 4'($urandom_range(1, 15));
            rd(a, v);
            check("R4", v, exp_reg(a));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule